// File: doc/BRIEF.md
# Inter-domain doorbell interrupt register block

This block is the register slave of a shared-memory mailbox device that links several compute domains. Software in the local domain reaches it through a simple 32-bit register bus over a 256-byte window. The block holds an interrupt mask, an interrupt status and a fixed position ID that identifies the local node. A level interrupt is raised whenever a status bit is set and its mask bit is also set. Reading the status register returns its contents and clears it in the same access.

Software notifies a remote domain by writing the doorbell register. That write carries a destination peer and a vector number. The block checks the pair against a table that records how many vectors each peer has registered. When the pair is valid, the block emits a one-cycle notification pulse together with the peer and vector. When it is not valid, the write is dropped without a trace.

The table is kept up to date through a side port. A connect strobe hands the named peer its next vector index. A disconnect strobe drops all of that peer's vectors. Incoming notifications for the local node arrive on a pulse input, and each one sets the status register to 1.

Top module: `dbell_regblk`

## Requirements
- R1: While reset is high and after it is released, the mask and status registers read zero and the interrupt output is low.
- R2: A write to word 0 replaces the whole 32-bit mask. Address bits 1:0 are ignored on every write, so byte offsets 0x0 to 0x3 all reach the mask.
- R3: A write to word 1 (byte offsets 0x4 to 0x7) replaces the whole 32-bit status value.
- R4: The interrupt output is high exactly when status AND mask is nonzero. It is registered and reflects the register state after the same clock edge that changed that state.
- R5: A read at offset 0x4 returns the status value as it was before the access and clears the status to zero at the same edge. The interrupt output is re-evaluated from the cleared value.
- R6: Reads decode the full 8-bit address. Offset 0x0 returns the mask, 0x4 returns the status, and 0x8 returns the position ID (parameter NODE_ID, zero-extended). Every other offset returns zero, including 0xC and any misaligned address, and such a read clears nothing. Read data appears on the cycle after the read strobe.
- R7: An incoming event pulse writes the value 1 into the status register; it does not OR into the existing bits. When an event coincides with a status read or a status write, the event wins.
- R8: A write to word 3 (offsets 0xC to 0xF) is a doorbell: bits 31:16 give the destination peer, bits 7:0 give the vector, and bits 15:8 are ignored. A valid doorbell raises the notify pulse for exactly one cycle, on the cycle after the write, and drives the registered peer and vector outputs with it.
- R9: A doorbell whose destination is greater than or equal to NUM_PEERS produces no pulse.
- R10: A doorbell whose vector is greater than or equal to the number of vectors registered for that peer produces no pulse.
- R11: A connect strobe raises the peer's registered count by one, so the Nth connect enables vector N-1. The count stops at NUM_VECS, and further connects are rejected. A disconnect strobe sets the count to zero and wins over a connect in the same cycle. Reset sets every count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 1 | Incoming notification pulse for the local node |
| tbl_peer | input | 4 | Peer addressed by the table side port |
| tbl_connect | input | 1 | Register the next vector for tbl_peer |
| tbl_disconnect | input | 1 | Drop all vectors of tbl_peer |
| irq_out | output | 1 | Level interrupt |
| ring_valid | output | 1 | One-cycle doorbell notification |
| ring_peer | output | 16 | Destination peer of the notification |
| ring_vec | output | 8 | Vector of the notification |

## Verification
The bench builds the block with its defaults: 16 peers, 4 vectors and position ID 3. This small configuration makes full sweeps practical. Every one of the 256 byte addresses is read, and the interrupt output is checked against all 256 pairings of 4-bit status and mask values. The doorbell sweep covers peers 0 to 17 and vectors 0 to 5, with every peer first given a vector count from 0 to 4. That places each accept/drop boundary of the peer table, including a destination just past the last peer, inside the sweep. Extra connects past the vector limit, disconnects, and collisions between events and status accesses are then checked one at a time.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  // Byte offsets of the register words; software depends on these.
  localparam int OFF_MASK = 'h0;
  localparam int OFF_STAT = 'h4;
  localparam int OFF_POS  = 'h8;
  localparam int OFF_RING = 'hC;
  localparam int DATA_W   = 32;

  typedef struct packed {
    logic [15:0] peer;
    logic [7:0]  vec;
  } ring_req_t;
endpackage

// File: rtl/dbell_peer_table.sv
module dbell_peer_table #(
  parameter int NUM_PEERS = 16,
  parameter int NUM_VECS  = 4,
  parameter int PEER_W    = 4,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PEER_W-1:0] tbl_peer,
  input  logic              tbl_connect,
  input  logic              tbl_disconnect,
  input  logic [15:0]       qry_peer,
  input  logic [7:0]        qry_vec,
  output logic              qry_ok
);
  logic [CNT_W-1:0] cnt_q [NUM_PEERS];

  for (genvar i = 0; i < NUM_PEERS; i++) begin : g_peer
    logic hit;
    assign hit = (tbl_peer == PEER_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[i] <= '0;
      end else if (tbl_disconnect && hit) begin
        cnt_q[i] <= '0;
      end else if (tbl_connect && hit && (cnt_q[i] < CNT_W'(NUM_VECS))) begin
        cnt_q[i] <= cnt_q[i] + 1'b1;
      end
    end
  end

  logic [PEER_W-1:0] idx;
  logic              in_range;
  assign idx      = qry_peer[PEER_W-1:0];
  assign in_range = (32'(qry_peer) < NUM_PEERS);
  assign qry_ok   = in_range && (32'(qry_vec) < 32'(cnt_q[idx]));
endmodule

// File: rtl/dbell_irq_core.sv
module dbell_irq_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr,
  input  logic              stat_wr,
  input  logic              stat_rd,
  input  logic              evt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq_q
);
  logic [DATA_W-1:0] mask_d, stat_d;

  always_comb begin
    mask_d = mask_wr ? wdata : mask_q;
    if (evt)          stat_d = DATA_W'(1);
    else if (stat_wr) stat_d = wdata;
    else if (stat_rd) stat_d = '0;
    else              stat_d = stat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_q  <= |(stat_d & mask_d);
    end
  end
endmodule

// File: rtl/dbell_ring_gen.sv
module dbell_ring_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       ok,
  input  logic [15:0] req_peer,
  input  logic [7:0]  req_vec,
  output logic       ring_valid,
  output logic [15:0] ring_peer,
  output logic [7:0]  ring_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ring_valid <= 1'b0;
      ring_peer  <= '0;
      ring_vec   <= '0;
    end else begin
      ring_valid <= fire && ok;
      if (fire && ok) begin
        ring_peer <= req_peer;
        ring_vec  <= req_vec;
      end
    end
  end
endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk #(
  parameter int          NUM_PEERS = 16,
  parameter int          NUM_VECS  = 4,
  parameter int          WIN_BYTES = 256,
  parameter logic [15:0] NODE_ID   = 16'd3,
  localparam int         ADDR_W    = $clog2(WIN_BYTES),
  localparam int         PEER_W    = $clog2(NUM_PEERS),
  localparam int         CNT_W     = $clog2(NUM_VECS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              evt_in,
  input  logic [PEER_W-1:0] tbl_peer,
  input  logic              tbl_connect,
  input  logic              tbl_disconnect,
  output logic              irq_out,
  output logic              ring_valid,
  output logic [15:0]       ring_peer,
  output logic [7:0]        ring_vec
);
  import dbell_pkg::*;

  // Writes ignore the two low address bits; reads match exactly.
  logic [ADDR_W-1:0] wr_word_addr;
  logic wr_mask, wr_stat, wr_ring, rd_stat;
  assign wr_word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
  assign wr_mask = bus_wr && (wr_word_addr == ADDR_W'(OFF_MASK));
  assign wr_stat = bus_wr && (wr_word_addr == ADDR_W'(OFF_STAT));
  assign wr_ring = bus_wr && (wr_word_addr == ADDR_W'(OFF_RING));
  assign rd_stat = bus_rd && (bus_addr == ADDR_W'(OFF_STAT));

  logic [DATA_W-1:0] mask_q, stat_q;

  dbell_irq_core #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst),
    .mask_wr(wr_mask), .stat_wr(wr_stat), .stat_rd(rd_stat), .evt(evt_in),
    .wdata(bus_wdata),
    .mask_q(mask_q), .stat_q(stat_q), .irq_q(irq_out)
  );

  ring_req_t req;
  logic      req_ok;
  assign req.peer = bus_wdata[31:16];
  assign req.vec  = bus_wdata[7:0];

  dbell_peer_table #(
    .NUM_PEERS(NUM_PEERS), .NUM_VECS(NUM_VECS), .PEER_W(PEER_W), .CNT_W(CNT_W)
  ) u_tbl (
    .clk(clk), .rst(rst),
    .tbl_peer(tbl_peer), .tbl_connect(tbl_connect), .tbl_disconnect(tbl_disconnect),
    .qry_peer(req.peer), .qry_vec(req.vec), .qry_ok(req_ok)
  );

  dbell_ring_gen u_ring (
    .clk(clk), .rst(rst),
    .fire(wr_ring), .ok(req_ok),
    .req_peer(req.peer), .req_vec(req.vec),
    .ring_valid(ring_valid), .ring_peer(ring_peer), .ring_vec(ring_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFF_MASK))      bus_rdata <= mask_q;
      else if (bus_addr == ADDR_W'(OFF_STAT)) bus_rdata <= stat_q;
      else if (bus_addr == ADDR_W'(OFF_POS))  bus_rdata <= {16'h0, NODE_ID};
      else                                    bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/dbell_regblk_chk.sv
module dbell_regblk_chk #(
  parameter int NUM_PEERS = 16,
  parameter int ADDR_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic              evt_in,
  input logic [31:0]       mask_q,
  input logic [31:0]       stat_q,
  input logic              irq_out,
  input logic              ring_valid,
  input logic [15:0]       ring_peer
);
  logic stat_wr_c, mask_wr_c, ring_wr_c, stat_rd_c;
  assign stat_wr_c = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign mask_wr_c = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(0));
  assign ring_wr_c = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
  assign stat_rd_c = bus_rd && (bus_addr == ADDR_W'(4));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == 32'h0 && stat_q == 32'h0 && !irq_out));

  // R4
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|(stat_q & mask_q)));

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    mask_wr_c |=> mask_q == $past(bus_wdata));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_c && !evt_in && !stat_wr_c) |=> stat_q == 32'h0);

  // R7
  event_one_chk: assert property (@(posedge clk) disable iff (rst)
    evt_in |=> stat_q == 32'h1);

  // R8
  ring_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ring_valid) |-> $past(ring_wr_c));

  // R9
  ring_range_chk: assert property (@(posedge clk) disable iff (rst)
    ring_valid |-> (32'(ring_peer) < NUM_PEERS));
endmodule

bind dbell_regblk dbell_regblk_chk #(.NUM_PEERS(NUM_PEERS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rd(bus_rd), .evt_in(evt_in), .mask_q(mask_q), .stat_q(stat_q),
  .irq_out(irq_out), .ring_valid(ring_valid), .ring_peer(ring_peer)
);

// File: tb/dbell_regblk_bench.sv
`timescale 1ns/1ps
module dbell_regblk_bench;
  localparam int NP = 16;
  localparam int NV = 4;
  localparam logic [15:0] ID = 16'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        evt_in = 1'b0;
  logic [3:0]  tbl_peer = '0;
  logic        tbl_connect = 1'b0;
  logic        tbl_disconnect = 1'b0;
  logic        irq_out, ring_valid;
  logic [15:0] ring_peer;
  logic [7:0]  ring_vec;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dbell_regblk #(.NUM_PEERS(NP), .NUM_VECS(NV), .NODE_ID(ID)) u_dbell_regblk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .evt_in(evt_in), .tbl_peer(tbl_peer),
    .tbl_connect(tbl_connect), .tbl_disconnect(tbl_disconnect), .irq_out(irq_out),
    .ring_valid(ring_valid), .ring_peer(ring_peer), .ring_vec(ring_vec)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // All tasks are entered at a falling edge and return at the next one.
  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic tconn(input int p, input bit disc, input bit conn);
    tbl_peer = 4'(p); tbl_disconnect = disc; tbl_connect = conn;
    @(negedge clk);
    tbl_disconnect = 1'b0; tbl_connect = 1'b0;
  endtask

  task automatic ring_expect(input int p, input int v, input bit exp_ok, input string req);
    bwrite(8'h0C | 8'(v & 3), {16'(p), 8'h5A, 8'(v)});
    chk(ring_valid == exp_ok, req, 32'(ring_valid), 32'(exp_ok));
    if (exp_ok && ring_valid)
      chk(ring_peer == 16'(p) && ring_vec == 8'(v), req, {ring_peer, 8'h0, ring_vec}, {16'(p), 8'h0, 8'(v)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: outputs held during reset
    chk(irq_out == 1'b0 && ring_valid == 1'b0, "R1 reset outputs", {30'h0, irq_out, ring_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    bread(8'h00, rd); chk(rd == 32'h0, "R1 mask after reset", rd, 32'h0);
    bread(8'h04, rd); chk(rd == 32'h0, "R1 status after reset", rd, 32'h0);

    // R2: every low-bit variant reaches the mask
    for (int lsb = 0; lsb < 4; lsb++) begin
      bwrite(8'(lsb), 32'hC0DE0000 | 32'(lsb));
      bread(8'h00, rd);
      chk(rd == (32'hC0DE0000 | 32'(lsb)), "R2 mask write low bits ignored", rd, 32'hC0DE0000 | 32'(lsb));
    end

    // R3: status write replaces, via misaligned address too
    bwrite(8'h04, 32'hF0F0_00F0);
    bwrite(8'h07, 32'h0000_000F);
    bread(8'h04, rd); chk(rd == 32'h0000_000F, "R3 status replaced", rd, 32'hF);

    // R6: misaligned status read neither returns nor clears
    bwrite(8'h04, 32'h3);
    bread(8'h05, rd); chk(rd == 32'h0, "R6 misaligned read returns zero", rd, 32'h0);
    bread(8'h04, rd); chk(rd == 32'h3, "R6 misaligned read cleared nothing", rd, 32'h3);

    // R6: full address sweep with status zero, mask 0xA5
    bwrite(8'h00, 32'hA5);
    for (int a = 0; a < 256; a++) begin
      logic [31:0] e;
      e = (a == 0) ? 32'hA5 : (a == 8) ? {16'h0, ID} : 32'h0;
      bread(8'(a), rd);
      chk(rd == e, $sformatf("R6 read sweep addr 0x%02h", a), rd, e);
    end

    // R4: all 4-bit status/mask pairings
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        bwrite(8'h04, 32'(s) << 28 | 32'(s));
        bwrite(8'h00, 32'(m));
        chk(irq_out == ((s & m) != 0), "R4 irq level", 32'(irq_out), 32'((s & m) != 0));
      end
    end

    // R5: read returns old value, clears, drops irq at once
    bwrite(8'h00, 32'h1);
    bwrite(8'h04, 32'h55);
    chk(irq_out == 1'b1, "R5 irq before read", 32'(irq_out), 32'h1);
    bread(8'h04, rd);
    chk(rd == 32'h55, "R5 read returns value", rd, 32'h55);
    chk(irq_out == 1'b0, "R5 irq after clearing read", 32'(irq_out), 32'h0);
    bread(8'h04, rd); chk(rd == 32'h0, "R5 status cleared", rd, 32'h0);

    // R7: event writes 1, not OR
    bwrite(8'h04, 32'h6);
    evt_in = 1'b1; @(negedge clk); evt_in = 1'b0;
    chk(irq_out == 1'b1, "R7 event raises irq", 32'(irq_out), 32'h1);
    bread(8'h04, rd); chk(rd == 32'h1, "R7 event sets status to 1", rd, 32'h1);
    // R7: event beats simultaneous read
    bwrite(8'h04, 32'h6);
    evt_in = 1'b1; bread(8'h04, rd); evt_in = 1'b0;
    chk(rd == 32'h6, "R7 collided read value", rd, 32'h6);
    bread(8'h04, rd); chk(rd == 32'h1, "R7 event survives read", rd, 32'h1);
    // R7: event beats simultaneous write
    evt_in = 1'b1; bwrite(8'h04, 32'hF0); evt_in = 1'b0;
    bread(8'h04, rd); chk(rd == 32'h1, "R7 event beats write", rd, 32'h1);

    // R11: peer p gets p%5 vectors
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < p % 5; k++) tconn(p, 1'b0, 1'b1);

    // R8 R9 R10: doorbell sweep
    for (int p = 0; p < NP + 2; p++) begin
      for (int v = 0; v < NV + 2; v++) begin
        bit ok;
        ok = (p < NP) && (v < p % 5);
        ring_expect(p, v, ok, (p >= NP) ? "R9 peer range" : (ok ? "R8 doorbell accepted" : "R10 vector range"));
      end
    end
    ring_expect(32'h8001, 0, 1'b0, "R9 high peer id");
    // R8: pulse lasts one cycle
    ring_expect(4, 3, 1'b1, "R8 valid doorbell");
    @(negedge clk);
    chk(ring_valid == 1'b0, "R8 single-cycle pulse", 32'(ring_valid), 32'h0);

    // R11: excess connects rejected
    for (int k = 0; k < 6; k++) tconn(0, 1'b0, 1'b1);
    ring_expect(0, 3, 1'b1, "R11 last vector registered");
    ring_expect(0, 4, 1'b0, "R11 excess connect rejected");
    // R11: disconnect clears, and wins over connect
    tconn(4, 1'b1, 1'b0);
    ring_expect(4, 0, 1'b0, "R11 disconnect clears");
    tconn(3, 1'b1, 1'b1);
    ring_expect(3, 0, 1'b0, "R11 disconnect wins");
    tconn(3, 1'b0, 1'b1);
    ring_expect(3, 0, 1'b1, "R11 reconnect gives vector 0");
    ring_expect(3, 1, 1'b0, "R11 reconnect gives only vector 0");

    // R1: reset mid-run
    bwrite(8'h00, 32'hFF); bwrite(8'h04, 32'hFF);
    rst = 1'b1; @(negedge clk); @(negedge clk);
    chk(irq_out == 1'b0, "R1 irq after reset", 32'(irq_out), 32'h0);
    rst = 1'b0; @(negedge clk);
    bread(8'h00, rd); chk(rd == 32'h0, "R1 mask cleared by reset", rd, 32'h0);
    bread(8'h04, rd); chk(rd == 32'h0, "R1 status cleared by reset", rd, 32'h0);
    ring_expect(1, 0, 1'b0, "R11 reset clears table");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule